// File: doc/BRIEF.md
# Configurable Six-Input LUT Cluster

This block is a small reconfigurable logic fabric. Sixteen lookup tables each hold a 64-bit truth table and compute one output bit from six address inputs. Each table input is steered by its own routing selection, which can pick any registered table output in the cluster or any of the external input wires. All tables evaluate in parallel on every clock, and each result is captured in an output register. The cluster edge carries 112 input wires, which is the same count as the six inputs and one output of all sixteen tables together, so the boundary has as much bandwidth as the inside.

The function of the cluster is set only by a serial configuration load. While the load enable is high, one bit enters on every clock: first all the table bits, then all the routing selections. The outputs stay at zero during the load. A done flag shows that a complete image has been stored. Reset clears the outputs and the load state but keeps the stored image, so the cluster resumes its function after reset.

Top module: `lut_cluster`

## Requirements
- R1: When `cfg_en` is low, `lut_out[t]` after a clock edge equals bit `a` of table `t`, where address bit `j` of `a` is the source picked by input `j` of table `t` before that edge.
- R2: All sixteen tables update their registered outputs on the same edge, every cycle that `cfg_en` is low.
- R3: A select value `s` below 16 picks `lut_out[s]`. A value from 16 to 127 picks `ext_in[s-16]`. 127 picks `ext_in[111]`.
- R4: Load position `n` fills bit `n%64` of table `n/64` for `n` below 1024. At positions 1024 and above, with `m = n-1024`, it fills bit `m%7` (least significant bit first) of the select for input `(m%42)/7` of table `m/42`.
- R5: Every edge taken with `cfg_en` high sets all outputs to 0.
- R6: `cfg_done` goes low on the edge that takes load position 0. It goes high on the edge that takes position 1695, so it is seen one cycle after the last bit is presented.
- R7: Bits presented after position 1695, while `cfg_en` stays high, are ignored. Lowering `cfg_en` and raising it again restarts the load at position 0.
- R8: A synchronous `rst` clears the outputs, the load position and `cfg_done`. The stored tables and selects are unchanged.
- R9: While `cfg_en` is low, `cfg_din` has no effect on the stored configuration or on `cfg_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Configuration load enable |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_done | output | 1 | A complete image has been stored |
| ext_in | input | 112 | External signal wires into the routing |
| lut_out | output | 16 | Registered table outputs |

## Verification
The assertions assume that `rst` is asserted from time zero until after the first edge. They also assume that `cfg_done` changes only under load or reset, so that no edge has it changing while both `cfg_en` and `rst` are low. The stimulus meets these assumptions by holding reset over the first edges and by changing `cfg_en`, `cfg_din` and `ext_in` only on falling clock edges. The table checks assume a complete load has been done before evaluation starts. The bench always loads a full image before it checks any output and never reads outputs from tables that were never written.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
   localparam int unsigned LUTC_NUM_DEF   = 16;
   localparam int unsigned LUTC_K_DEF     = 6;
   localparam int unsigned LUTC_SEL_W_DEF = 7;
   localparam int unsigned LUTC_EXT_DEF   = 112;

   // total serial configuration length: table bits, then routing selections
   function automatic int unsigned lutc_cfg_bits(input int unsigned n,
                                                 input int unsigned k,
                                                 input int unsigned w);
      return n * (1 << k) + n * k * w;
   endfunction
endpackage

// File: rtl/lutc_cfg_ctrl.sv
module lutc_cfg_ctrl #(
   parameter int unsigned TOTAL = 1696,
   parameter int unsigned IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_en,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             done
);
   logic [IDX_W-1:0] pos;
   logic             in_range;

   assign in_range = (pos < IDX_W'(TOTAL));
   assign wr_en    = cfg_en && in_range;
   assign wr_idx   = pos;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos  <= '0;
         done <= 1'b0;
      end else if (!cfg_en) begin
         pos <= '0;
      end else begin
         if (in_range) pos <= pos + 1'b1;
         if (pos == '0) done <= 1'b0;
         if (pos == IDX_W'(TOTAL - 1)) done <= 1'b1;
      end
   end
endmodule

// File: rtl/lutc_table.sv
module lutc_table #(
   parameter int unsigned K     = 6,
   parameter int unsigned BASE  = 0,
   parameter int unsigned IDX_W = 11
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             din,
   input  logic [K-1:0]     addr,
   output logic             bit_o
);
   localparam int unsigned DEPTH = 1 << K;

   logic [DEPTH-1:0] tbl;

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (wr_en && (wr_idx == IDX_W'(BASE + e))) tbl[e] <= din;
      end
   end

   assign bit_o = tbl[addr];
endmodule

// File: rtl/lutc_route.sv
module lutc_route #(
   parameter int unsigned K     = 6,
   parameter int unsigned SEL_W = 7,
   parameter int unsigned SRC_W = 128,
   parameter int unsigned BASE  = 1024,
   parameter int unsigned IDX_W = 11
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             din,
   input  logic [SRC_W-1:0] src,
   output logic [K-1:0]     addr
);
   localparam int unsigned SEL_BITS = K * SEL_W;
   localparam int unsigned NSRC     = 1 << SEL_W;

   logic [SEL_BITS-1:0] selv;
   logic [NSRC-1:0]     src_pad;

   always_ff @(posedge clk) begin
      for (int e = 0; e < SEL_BITS; e++) begin
         if (wr_en && (wr_idx == IDX_W'(BASE + e))) selv[e] <= din;
      end
   end

   generate
      if (SRC_W == NSRC) begin : g_full
         assign src_pad = src;
      end else begin : g_pad
         assign src_pad = {{(NSRC - SRC_W){1'b0}}, src};
      end
   endgenerate

   for (genvar j = 0; j < K; j++) begin : g_in
      assign addr[j] = src_pad[selv[j*SEL_W +: SEL_W]];
   end
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
   import lutc_pkg::*;
#(
   parameter int unsigned NUM_LUT = LUTC_NUM_DEF,
   parameter int unsigned LUT_K   = LUTC_K_DEF,
   parameter int unsigned SEL_W   = LUTC_SEL_W_DEF,
   parameter int unsigned EXT_IN  = LUTC_EXT_DEF
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cfg_en,
   input  logic               cfg_din,
   output logic               cfg_done,
   input  logic [EXT_IN-1:0]  ext_in,
   output logic [NUM_LUT-1:0] lut_out
);
   localparam int unsigned TBL_BITS  = 1 << LUT_K;
   localparam int unsigned TBL_TOTAL = NUM_LUT * TBL_BITS;
   localparam int unsigned SEL_PER   = LUT_K * SEL_W;
   localparam int unsigned CFG_TOTAL = lutc_cfg_bits(NUM_LUT, LUT_K, SEL_W);
   localparam int unsigned IDX_W     = $clog2(CFG_TOTAL + 1);
   localparam int unsigned SRC_W     = NUM_LUT + EXT_IN;

   if (SRC_W > (1 << SEL_W)) begin : g_bad_sel
      $error("lut_cluster: select width too small for source count");
   end
   if (LUT_K < 1 || NUM_LUT < 1) begin : g_bad_size
      $error("lut_cluster: LUT_K and NUM_LUT must be at least 1");
   end

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [NUM_LUT-1:0] lut_bit;
   logic [NUM_LUT-1:0] out_q;
   logic [SRC_W-1:0]   src;

   assign src     = {ext_in, out_q};
   assign lut_out = out_q;

   lutc_cfg_ctrl #(.TOTAL(CFG_TOTAL), .IDX_W(IDX_W)) ctrl_i (
      .clk    (clk),
      .rst    (rst),
      .cfg_en (cfg_en),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .done   (cfg_done)
   );

   for (genvar g = 0; g < NUM_LUT; g++) begin : g_lut
      logic [LUT_K-1:0] addr;

      lutc_route #(
         .K(LUT_K), .SEL_W(SEL_W), .SRC_W(SRC_W),
         .BASE(TBL_TOTAL + g * SEL_PER), .IDX_W(IDX_W)
      ) route_i (
         .clk    (clk),
         .wr_en  (wr_en),
         .wr_idx (wr_idx),
         .din    (cfg_din),
         .src    (src),
         .addr   (addr)
      );

      lutc_table #(.K(LUT_K), .BASE(g * TBL_BITS), .IDX_W(IDX_W)) table_i (
         .clk    (clk),
         .wr_en  (wr_en),
         .wr_idx (wr_idx),
         .din    (cfg_din),
         .addr   (addr),
         .bit_o  (lut_bit[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst || cfg_en) out_q <= '0;
      else               out_q <= lut_bit;
   end
endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk #(
   parameter int unsigned NUM_LUT = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               cfg_en,
   input logic               cfg_done,
   input logic [NUM_LUT-1:0] lut_out
);
   logic rst_d = 1'b0;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst_d) begin
         a_out_clear_r8: assert (lut_out == '0 && !cfg_done)
            else $error("outputs or done not cleared after reset");
      end
   end

   p_zero_in_cfg_r5: assert property (@(posedge clk) disable iff (rst)
      cfg_en |=> (lut_out == '0));

   p_done_rise_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(cfg_done) |-> $past(cfg_en));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !cfg_en |=> $stable(cfg_done));

   p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (cfg_en && cfg_done) |=> (cfg_done || !$past(cfg_en, 2)));
endmodule

bind lut_cluster lut_cluster_chk #(.NUM_LUT(NUM_LUT)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .cfg_en   (cfg_en),
   .cfg_done (cfg_done),
   .lut_out  (lut_out)
);

// File: tb/lut_cluster_tb_top.sv
module lut_cluster_tb_top;
   localparam int NL    = 16;
   localparam int NE    = 112;
   localparam int TOTAL = 1696;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_en = 1'b0;
   logic          cfg_din = 1'b0;
   logic          cfg_done;
   logic [NE-1:0] ext_in = '0;
   logic [NL-1:0] lut_out;

   int checks = 0;
   int errors = 0;
   logic [63:0] tbl [NL];
   int          sel [NL][6];

   always #2 clk = ~clk;

   lut_cluster dut_i (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .cfg_done(cfg_done), .ext_in(ext_in), .lut_out(lut_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R4 serial order
   function automatic logic cfg_bit(input int n);
      int m;
      if (n < 1024) return tbl[n / 64][n % 64];
      m = n - 1024;
      return 1'((sel[m / 42][(m % 42) / 7] >> (m % 7)) & 1);
   endfunction

   task automatic load(input int extra);
      cfg_en = 1'b1;
      for (int n = 0; n < TOTAL + extra; n++) begin
         cfg_din = (n < TOTAL) ? cfg_bit(n) : 1'b1;
         @(negedge clk);
         if (n == 0) begin
            chk("R6 done low at load start", 32'(cfg_done), 0);
            chk("R5 outputs zero in load", 32'(lut_out), 0);
         end
         if (n == TOTAL - 2) chk("R6 done low before last bit", 32'(cfg_done), 0);
         if (n == TOTAL - 1) chk("R6 done after last bit", 32'(cfg_done), 1);
         if (n == TOTAL + extra - 1) begin
            chk("R7 done held over extra bits", 32'(cfg_done), 1);
            chk("R5 outputs zero at load end", 32'(lut_out), 0);
         end
      end
      cfg_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [NL-1:0] exp;
      logic m0, m1, m2, m3;
      repeat (3) @(negedge clk);
      chk("R8 reset outputs", 32'(lut_out), 0);
      chk("R8 reset done", 32'(cfg_done), 0);
      rst = 1'b0;

      // image A: every table fed from its own six external wires
      for (int i = 0; i < NL; i++) begin
         for (int a = 0; a < 64; a++) tbl[i][a] = 1'(((a * (i + 7) + i * 13) >> 3) & 1);
         for (int j = 0; j < 6; j++) sel[i][j] = 16 + i * 6 + j;
      end
      load(0);
      // R1 R2 R3 R9: exhaustive address sweep for every table
      for (int c = 0; c < 64; c++) begin
         for (int i = 0; i < NL; i++) ext_in[i*6 +: 6] = 6'((c ^ (i * 11)) & 63);
         ext_in[NE-1:96] = 16'(c * 1031);
         cfg_din = 1'(c & 1);
         @(negedge clk);
         for (int i = 0; i < NL; i++) exp[i] = tbl[i][(c ^ (i * 11)) & 63];
         chk("R1 R2 table lookup sweep", 32'(lut_out), 32'(exp));
         chk("R9 done stable while idle", 32'(cfg_done), 1);
      end

      // image B: feedback routing and boundary selects
      for (int i = 0; i < NL; i++) begin
         tbl[i] = 64'h0;
         for (int j = 0; j < 6; j++) sel[i][j] = 16 + i;
      end
      tbl[0] = 64'h1;                   for (int j = 0; j < 6; j++) sel[0][j] = 0;
      tbl[1] = 64'h8000_0000_0000_0000; for (int j = 0; j < 6; j++) sel[1][j] = 0;
      tbl[2] = 64'h8000_0000_0000_0000; for (int j = 0; j < 6; j++) sel[2][j] = 127;
      tbl[3] = 64'h8000_0000_0000_0000; for (int j = 0; j < 6; j++) sel[3][j] = 16;
      sel[3][0] = 0;
      load(5);   // R7 restart at position 0 and extra bits ignored
      m0 = 0; m1 = 0; m2 = 0; m3 = 0;
      for (int c = 0; c < 60; c++) begin
         logic n0, n1, n2, n3;
         if (c == 40) begin
            rst = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk("R8 outputs cleared by reset", 32'(lut_out), 0);
            chk("R8 done cleared by reset", 32'(cfg_done), 0);
            rst = 1'b0;
            m0 = 0; m1 = 0; m2 = 0; m3 = 0;
         end
         ext_in = '0;
         ext_in[NE-1] = 1'((c >> 1) & 1);
         ext_in[0]    = 1'((c % 3) != 0);
         cfg_din = 1'(~c & 1);
         n0 = ~m0; n1 = m0; n2 = ext_in[NE-1]; n3 = m0 & ext_in[0];
         m0 = n0; m1 = n1; m2 = n2; m3 = n3;
         @(negedge clk);
         chk("R3 R8 feedback and boundary selects", 32'(lut_out), 32'({m3, m2, m1, m0}));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule